// File: doc/BRIEF.md
# Token-Passing Ring Access Controller

This block grants access to a shared resource by passing a single token word around a closed ring of identical node interfaces. Every node serves one local requester through a request, grant and done handshake. A node can grant its requester only while it holds the token. The token moves only to the next node on the ring, and it moves only after the local transaction has ended. No central arbiter is involved. The order of access comes from the position of the nodes on the ring.

After reset the ring holds exactly one token, and node 0 sees it first. A node that has no pending request passes the token on in one clock. A node with a pending request keeps the token and asserts its grant until the requester pulses done. The token word carries a valid bit, a fixed tag and an even-parity bit. A node that receives a word with bad parity records a sticky error flag and discards the word. A per-link fault input flips the parity bit of the word entering a node, so that this path can be exercised.

Top module: `token_ring_ctrl`

## Requirements
- R1: At no time are two grants high together, and at most one valid token exists in the ring (on a link or held by a node).
- R2: After reset is released, the token reaches node 0 at the first clock edge and node k at edge k, counting that first edge as edge 0. The first edge is the one that sees reset low.
- R3: A node whose request is low when the token arrives forwards the token within the same clock, so the next node sees it one edge later.
- R4: A node whose request is high when the token arrives raises its grant right after that edge.
- R5: A grant stays high for as long as done stays low, whatever the other inputs do.
- R6: Done sampled high while a grant is high drops that grant after the same edge and releases the token. The next node sees the token one edge later, which gives a single idle cycle with no grant between two owners.
- R7: Done pulses at a node that holds no grant are ignored, and the current holder keeps its grant.
- R8: The token word is {valid, 4-bit tag 1010, parity}, with even parity over all six bits, and an idle link carries all zeros. fault[i] flips the parity bit of the word entering node i.
- R9: A node that receives a word with bad parity sets err[i] one edge later and keeps it until reset. If that word was the token, it is discarded, and no grant is ever given again until reset.
- R10: A bad word on an idle link sets the error flag but leaves the real token in circulation.
- R11: When all nodes request continuously, grants follow ring order 0, 1, 2, ... N-1, 0 and so on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | N | Per-node access request |
| done | input | N | Per-node end-of-transaction pulse |
| fault | input | N | Flips the parity bit of the word entering each node |
| grant | output | N | Per-node access grant |
| err | output | N | Per-node sticky corrupted-word flag |

## Verification
The bench sweeps the requesting node over every ring position after reset and checks the exact edge at which the grant rises. A design that injected the token at the wrong node, or that added a register on each hop, would be off by a fixed number of cycles there. Release handover is timed to the cycle and checked for ring order under full load. This exposes a design that moves the token early, keeps the grant after done, or acts on done from a node that holds no grant. A parity fault placed exactly on the token must leave the ring without a token, while a fault on an idle link must not. A design that used a corrupted token, or that dropped the flag, would fail these checks.

// File: rtl/ring_pkg.sv
package ring_pkg;

    localparam int TAG_W = 4;
    localparam logic [TAG_W-1:0] TOKEN_TAG = 4'b1010;

    // Word moving between neighbouring nodes.
    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        logic             par;
    } ring_word_t;

    typedef enum logic {
        ND_WAIT = 1'b0,
        ND_OWN  = 1'b1
    } node_state_t;

    localparam ring_word_t IDLE_WORD = '0;

    function automatic ring_word_t token_word();
        ring_word_t w;
        w.valid = 1'b1;
        w.tag   = TOKEN_TAG;
        w.par   = ^{1'b1, TOKEN_TAG};
        return w;
    endfunction

    // Even parity over the whole word.
    function automatic logic parity_good(ring_word_t w);
        return (^w) == 1'b0;
    endfunction

endpackage

// File: rtl/ring_word_check.sv
module ring_word_check
    import ring_pkg::*;
(
    input  ring_word_t w,
    output logic       usable,
    output logic       corrupt
);
    always_comb begin
        corrupt = !parity_good(w);
        usable  = parity_good(w) && w.valid && (w.tag == TOKEN_TAG);
    end
endmodule

// File: rtl/ring_node.sv
module ring_node
    import ring_pkg::*;
#(
    parameter bit INJECT = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  ring_word_t word_in,
    input  logic       req,
    input  logic       done,
    output ring_word_t word_out,
    output logic       grant,
    output logic       err
);
    node_state_t state;
    logic        tok_ok;
    logic        tok_bad;

    ring_word_check u_chk (
        .w       (word_in),
        .usable  (tok_ok),
        .corrupt (tok_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ND_WAIT;
            word_out <= INJECT ? token_word() : IDLE_WORD;
            err      <= 1'b0;
        end else begin
            word_out <= IDLE_WORD;
            if (tok_bad)
                err <= 1'b1;
            unique case (state)
                ND_WAIT: begin
                    if (tok_ok) begin
                        if (req) state    <= ND_OWN;
                        else     word_out <= token_word();
                    end
                end
                ND_OWN: begin
                    if (done) begin
                        state    <= ND_WAIT;
                        word_out <= token_word();
                    end
                end
                default: state <= ND_WAIT;
            endcase
        end
    end

    assign grant = (state == ND_OWN);

    // R4: grant only rises after a usable token met a request
    a_r4_grant_on_token: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> $past(tok_ok && req));
    // R9: a corrupted word is never turned into a grant
    a_r9_no_use_bad: assert property (@(posedge clk) disable iff (rst)
        $rose(grant) |-> !$past(tok_bad));
    // R5: grant holds while done is low
    a_r5_grant_hold: assert property (@(posedge clk) disable iff (rst)
        (grant && !done) |=> grant);
    // R6: done releases grant and emits the token
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (grant && done) |=> (!grant && word_out.valid));
    // R3: idle node forwards an arriving token
    a_r3_forward: assert property (@(posedge clk) disable iff (rst)
        (!grant && tok_ok && !req) |=> word_out.valid);
    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

// File: rtl/token_ring_ctrl.sv
module token_ring_ctrl
    import ring_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic [N-1:0] done,
    input  logic [N-1:0] fault,
    output logic [N-1:0] grant,
    output logic [N-1:0] err
);
    ring_word_t   link_out [N];
    ring_word_t   link_in  [N];
    logic [N-1:0] link_valid;

    for (genvar i = 0; i < N; i++) begin : g_node
        localparam int PREV = (i == 0) ? N - 1 : i - 1;

        always_comb begin
            link_in[i]     = link_out[PREV];
            link_in[i].par = link_out[PREV].par ^ fault[i];
        end

        assign link_valid[i] = link_out[i].valid;

        // The node before node 0 holds the token at reset, so node 0 sees it first.
        ring_node #(.INJECT(i == N - 1)) u_node (
            .clk      (clk),
            .rst      (rst),
            .word_in  (link_in[i]),
            .req      (req[i]),
            .done     (done[i]),
            .word_out (link_out[i]),
            .grant    (grant[i]),
            .err      (err[i])
        );
    end

    // R1: a single owner at any time
    a_r1_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));
    // R1: never more than one token in the ring
    a_r1_one_token: assert property (@(posedge clk) disable iff (rst)
        $countones({link_valid, grant}) <= 1);
endmodule

// File: tb/test_token_ring_ctrl.sv
`timescale 1ns/1ps
module test_token_ring_ctrl;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic [N-1:0] done = '0;
    logic [N-1:0] fault = '0;
    logic [N-1:0] grant;
    logic [N-1:0] err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int multi_grant = 0;

    always #4 clk = ~clk;

    token_ring_ctrl #(.N(N)) i_token_ring_ctrl (
        .clk(clk), .rst(rst), .req(req), .done(done), .fault(fault),
        .grant(grant), .err(err)
    );

    always @(negedge clk) begin
        cyc++;
        if (!rst && $countones(grant) > 1) multi_grant++;
        if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req = '0; done = '0; fault = '0;
        repeat (3) step();
        rst = 1'b0;
    endtask

    initial begin
        // Reset state
        do_reset();
        chk("reset grant", grant, '0);
        chk("reset err", err, '0);

        // R2 R3 R4: sweep requesting node; grant appears after edge k
        for (int k = 0; k < N; k++) begin
            do_reset();
            req = N'(1) << k;
            for (int e = 0; e <= k; e++) begin
                step();
                chk((e < k) ? "R3 R2 forward latency" : "R4 R2 grant after arrival",
                    grant, (e >= k) ? (N'(1) << k) : '0);
            end
        end

        // R5 R6 R7: hold, release and handover timing
        do_reset();
        req = 4'b0001;
        step();
        chk("R4 node0 grant", grant, 4'b0001);
        req = 4'b0101;
        for (int h = 0; h < 4; h++) begin
            step();
            chk("R5 grant held", grant, 4'b0001);
        end
        done = 4'b0001;
        step();
        done = '0; req = 4'b0100;
        chk("R6 release drops grant", grant, 4'b0000);
        step();
        chk("R6 idle cycle at node1", grant, 4'b0000);
        step();
        chk("R6 node2 takes token", grant, 4'b0100);
        done = 4'b1011;
        step();
        done = '0;
        chk("R7 foreign done ignored", grant, 4'b0100);
        step();
        chk("R7 holder keeps grant", grant, 4'b0100);

        // R11: full-load ring order
        do_reset();
        req = '1;
        step();
        chk("R11 first owner", grant, 4'b0001);
        for (int t = 0; t < 2 * N; t++) begin
            step();
            done = grant;
            step();
            done = '0;
            chk("R6 gap cycle", grant, '0);
            step();
            chk("R11 ring order", grant, N'(1) << ((t + 1) % N));
        end

        // R8 R9: corrupt the token on its way into node 2
        do_reset();
        step(); step();
        fault = 4'b0100;
        step();
        fault = '0;
        chk("R9 err at node2", err, 4'b0100);
        req = '1;
        for (int w = 0; w < 3 * N; w++) step();
        chk("R9 token discarded", grant, '0);
        chk("R9 err sticky", err, 4'b0100);

        // R10: corrupt an idle link; token survives
        do_reset();
        fault = 4'b1000;
        step();
        fault = '0;
        chk("R10 err at node3", err, 4'b1000);
        req = 4'b1000;
        for (int w = 0; w < 2 * N && grant == '0; w++) step();
        chk("R10 token still usable", grant, 4'b1000);

        // R1: no overlap of grants observed across the run
        chk("R1 single grant", N'(multi_grant), '0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule